// File: doc/BRIEF.md
# SECDED Codec for 32-bit Words

This block protects a 32-bit data word with seven check bits so that any single flipped bit in the 39-bit stored or transmitted word can be corrected and any two flipped bits can be detected. The encoder side is purely combinational. It takes a data word and returns the check bits. The caller forms the protected word by placing those check bits above the data, as `{check[6:0], data[31:0]}`.

The decoder side takes the received data and the received check bits on separate inputs. It also takes an enable and a mode select. Its outputs are the data word and two mutually exclusive flags, one for a single error and one for a double error. All three decoder outputs are registered one clock after their inputs.

In correcting mode, a single error is repaired. In detect-only mode, errors are still reported, but the data passes through untouched.

Top module: `secded32_codec`

## Requirements
- R1: Data bit i takes the i-th Hamming position in ascending order from the set {3,5,6,7,9,...,38}, which is the positions 1..38 with the powers of two removed. Check bit k (k = 0..5) is the XOR of the data bits whose position has bit k set. Check bit 6 makes the XOR of all 32 data bits and all 7 check bits equal to zero. The encoder output follows its input combinationally.
- R2: The protected word is `{check[6:0], data[31:0]}`. Codeword bit 32+k is check bit k, and codeword bit i < 32 is data bit i.
- R3: The decoder outputs change only on the rising clock edge after their inputs are applied. While reset is low, the data output and both flags are zero.
- R4: With enable = 1 and mode = 0 (correct), if exactly one of the 39 codeword bits is flipped, the data output equals the original data, the single flag is 1 and the double flag is 0. This holds when the flipped bit is a check bit.
- R5: With enable = 1, if exactly two distinct codeword bits are flipped, the double flag is 1, the single flag is 0, and the data output equals the received data without any correction.
- R6: With enable = 1 and mode = 1 (detect only), the flags behave as in mode 0, but the data output always equals the received data.
- R7: With enable = 0, both flags are 0 and the data output equals the received data, whatever errors are present.
- R8: With an error-free codeword, both flags are 0 and the data output equals the received data.
- R9: The single and double flags are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the decoder output registers |
| rst_n | input | 1 | Active-low synchronous reset of the decoder outputs |
| enc_data_i | input | 32 | Data word to encode |
| enc_check_o | output | 7 | Check bits for `enc_data_i` (combinational) |
| dec_data_i | input | 32 | Received data bits |
| dec_check_i | input | 7 | Received check bits |
| dec_en_i | input | 1 | Decoder enable; when low, no detection is done |
| dec_mode_i | input | 1 | 0 = correct single errors, 1 = detect only |
| dec_data_o | output | 32 | Decoded data, registered |
| dec_single_o | output | 1 | Single error seen, registered |
| dec_double_o | output | 1 | Double error seen, registered |

## Verification
The hardest situations to reach are the error patterns whose Hamming syndrome is zero or points away from the data. Examples are a flip of the overall parity bit alone, a flip of one low check bit, and two flips confined to the check field.

Random data with random flip positions reaches these patterns only rarely. The bench therefore sweeps a single flip across all 39 codeword positions, with both all-zero and all-one data. It also injects directed pairs that lie entirely in the check bits. A fixed-seed random mix covers error counts, positions, enable and mode.

// File: rtl/secded32_pkg.sv
package secded32_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CHK_W  = PAR_W + 1;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int POS_LIMIT = 1 << PAR_W;

  // Hamming position of data bit idx: the idx-th non-power-of-two from 3 up.
  function automatic logic [PAR_W-1:0] data_pos(input int idx);
    logic [PAR_W-1:0] res;
    int cnt;
    res = '0;
    cnt = 0;
    for (int p = 3; p < POS_LIMIT; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = PAR_W'(p);
        cnt++;
      end
    end
    return res;
  endfunction

  // Data bits covered by Hamming parity bit k.
  function automatic logic [DATA_W-1:0] cover_mask(input int k);
    logic [DATA_W-1:0] m;
    logic [PAR_W-1:0] pos;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pos = data_pos(i);
      m[i] = pos[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded32_encoder.sv
module secded32_encoder
  import secded32_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  check_o
);
  logic [PAR_W-1:0] ham;

  for (genvar k = 0; k < PAR_W; k++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = cover_mask(k);
    assign ham[k] = ^(data_i & MASK);
  end

  // Overall parity makes the XOR over all codeword bits zero.
  assign check_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/secded32_syndrome.sv
module secded32_syndrome
  import secded32_pkg::*;
(
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [CHK_W-1:0]  rx_check_i,
  output logic [PAR_W-1:0]  syndrome_o,
  output logic              parity_bad_o
);
  for (genvar k = 0; k < PAR_W; k++) begin : g_syn
    localparam logic [DATA_W-1:0] MASK = cover_mask(k);
    assign syndrome_o[k] = rx_check_i[k] ^ (^(rx_data_i & MASK));
  end

  assign parity_bad_o = (^rx_data_i) ^ (^rx_check_i);
endmodule

// File: rtl/secded32_corrector.sv
module secded32_corrector
  import secded32_pkg::*;
(
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [PAR_W-1:0]  syndrome_i,
  input  logic              parity_bad_i,
  input  logic              enable_i,
  input  logic              detect_only_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_evt_o,
  output logic              double_evt_o
);
  logic [DATA_W-1:0] flip_mask;
  logic              apply_fix;

  // One comparator per data bit; a check-bit syndrome matches none.
  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [PAR_W-1:0] POS = data_pos(i);
    assign flip_mask[i] = (syndrome_i == POS);
  end

  assign single_evt_o = enable_i & parity_bad_i;
  assign double_evt_o = enable_i & ~parity_bad_i & (|syndrome_i);
  assign apply_fix    = single_evt_o & ~detect_only_i;
  assign data_o       = apply_fix ? (rx_data_i ^ flip_mask) : rx_data_i;

  always_comb begin
    // R4: at most one data bit is ever a correction target
    a_r4_flip_onehot: assert ($onehot0(flip_mask));
    // R6: detect-only mode leaves the data untouched
    if (detect_only_i) a_r6_no_fix: assert (data_o == rx_data_i);
    // R5: a double error is never corrected
    if (double_evt_o) a_r5_no_fix: assert (data_o == rx_data_i);
  end
endmodule

// File: rtl/secded32_codec.sv
module secded32_codec
  import secded32_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       enc_data_i,
  output logic [6:0]        enc_check_o,
  input  logic [31:0]       dec_data_i,
  input  logic [6:0]        dec_check_i,
  input  logic              dec_en_i,
  input  logic              dec_mode_i,
  output logic [31:0]       dec_data_o,
  output logic              dec_single_o,
  output logic              dec_double_o
);
  logic [PAR_W-1:0]  syndrome;
  logic              parity_bad;
  logic [DATA_W-1:0] fixed_data;
  logic              single_evt;
  logic              double_evt;
  logic              primed;

  secded32_encoder u_enc (
    .data_i  (enc_data_i),
    .check_o (enc_check_o)
  );

  secded32_syndrome u_syn (
    .rx_data_i    (dec_data_i),
    .rx_check_i   (dec_check_i),
    .syndrome_o   (syndrome),
    .parity_bad_o (parity_bad)
  );

  secded32_corrector u_fix (
    .rx_data_i     (dec_data_i),
    .syndrome_i    (syndrome),
    .parity_bad_i  (parity_bad),
    .enable_i      (dec_en_i),
    .detect_only_i (dec_mode_i),
    .data_o        (fixed_data),
    .single_evt_o  (single_evt),
    .double_evt_o  (double_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_data_o   <= '0;
      dec_single_o <= 1'b0;
      dec_double_o <= 1'b0;
      primed       <= 1'b0;
    end else begin
      dec_data_o   <= fixed_data;
      dec_single_o <= single_evt;
      dec_double_o <= double_evt;
      primed       <= 1'b1;
    end
  end

  // R9: flags are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_single_o && dec_double_o));

  // R7: disabled decoder reports nothing and passes the data
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!dec_en_i) |->
      !dec_single_o && !dec_double_o && dec_data_o == $past(dec_data_i));

  // R8: a consistent codeword is passed through clean
  a_r8_clean: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(syndrome == '0 && !parity_bad) |->
      !dec_single_o && !dec_double_o && dec_data_o == $past(dec_data_i));

  // R6: detect-only mode never alters the registered data
  a_r6_mode: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(dec_mode_i) |-> dec_data_o == $past(dec_data_i));

  // R3: registered flags follow the events one cycle later
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> dec_single_o == $past(single_evt) && dec_double_o == $past(double_evt));
endmodule

// File: tb/secded32_codec_bench.sv
module secded32_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_data_i = '0;
  logic [6:0]  enc_check_o;
  logic [31:0] dec_data_i = '0;
  logic [6:0]  dec_check_i = '0;
  logic        dec_en_i = 1'b0;
  logic        dec_mode_i = 1'b0;
  logic [31:0] dec_data_o;
  logic        dec_single_o;
  logic        dec_double_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  secded32_codec u_secded32_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
    .dec_data_i(dec_data_i), .dec_check_i(dec_check_i),
    .dec_en_i(dec_en_i), .dec_mode_i(dec_mode_i),
    .dec_data_o(dec_data_o), .dec_single_o(dec_single_o),
    .dec_double_o(dec_double_o)
  );

  // Reference encoder: spread data over positions 1..38, skip powers of two.
  function automatic logic [6:0] ref_check(input logic [31:0] d);
    logic [38:1] h;
    logic [6:0]  c;
    int di;
    h = '0;
    di = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        h[p] = d[di];
        di++;
      end
    end
    c = '0;
    for (int k = 0; k < 6; k++)
      for (int p = 1; p <= 38; p++)
        if (((p >> k) & 1) == 1) c[k] = c[k] ^ h[p];
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // nerr flips at codeword positions e1, e2 (0..38, 32+ = check bits)
  task automatic run_case(input logic [31:0] d, input int nerr, input int e1,
                          input int e2, input logic en, input logic mode);
    logic [38:0] cw;
    logic [31:0] exp_data;
    logic        exp_s, exp_d;
    string req;
    @(negedge clk);
    enc_data_i = d;
    #1;
    check("R1", "check bits", {25'd0, enc_check_o}, {25'd0, ref_check(d)});
    cw = {enc_check_o, d};
    if (nerr >= 1) cw[e1] = ~cw[e1];
    if (nerr >= 2) cw[e2] = ~cw[e2];
    dec_data_i  = cw[31:0];   // R2 layout: data low, check bits high
    dec_check_i = cw[38:32];
    dec_en_i    = en;
    dec_mode_i  = mode;
    exp_s = en && nerr == 1;
    exp_d = en && nerr == 2;
    exp_data = (exp_s && !mode) ? d : cw[31:0];
    if (!en) req = "R7";
    else if (nerr == 0) req = "R8";
    else if (mode) req = "R6";
    else if (nerr == 1) req = "R4";
    else req = "R5";
    @(posedge clk);
    @(negedge clk);
    check(req, "data", dec_data_o, exp_data);
    check(req, "single", {31'd0, dec_single_o}, {31'd0, exp_s});
    check(req, "double", {31'd0, dec_double_o}, {31'd0, exp_d});
    check("R9", "exclusive", {31'd0, dec_single_o && dec_double_o}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EC0_0D3D));
    // R3: reset holds outputs at zero with busy inputs
    dec_data_i = 32'hDEAD_BEEF;
    dec_check_i = 7'h55;
    dec_en_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R3", "reset data", dec_data_o, 32'd0);
    check("R3", "reset flags", {30'd0, dec_single_o, dec_double_o}, 32'd0);
    rst_n = 1'b1;

    // R4: single flip swept across all positions, two data patterns
    for (int e = 0; e < 39; e++) run_case(32'h0000_0000, 1, e, 0, 1'b1, 1'b0);
    for (int e = 0; e < 39; e++) run_case(32'hFFFF_FFFF, 1, e, 0, 1'b1, 1'b0);
    // R5: pairs inside the check field and across the boundary
    run_case(32'h1234_5678, 2, 32, 38, 1'b1, 1'b0);
    run_case(32'h1234_5678, 2, 33, 34, 1'b1, 1'b0);
    run_case(32'hA5A5_5A5A, 2, 0, 31, 1'b1, 1'b0);
    run_case(32'hA5A5_5A5A, 2, 31, 38, 1'b1, 1'b0);
    // R6: detect-only with a data flip
    run_case(32'hCAFE_F00D, 1, 7, 0, 1'b1, 1'b1);
    // R7: disabled with single and double errors
    run_case(32'hCAFE_F00D, 1, 3, 0, 1'b0, 1'b0);
    run_case(32'hCAFE_F00D, 2, 3, 9, 1'b0, 1'b0);
    // R8: clean words
    run_case(32'h8000_0001, 0, 0, 0, 1'b1, 1'b0);

    // R3: output holds until the next edge
    run_case(32'h0F0F_0F0F, 0, 0, 0, 1'b1, 1'b0);
    @(negedge clk);
    dec_data_i = 32'h1111_2222;
    dec_check_i = ref_check(32'h1111_2222);
    #1;
    check("R3", "hold before edge", dec_data_o, 32'h0F0F_0F0F);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] d;
      int ne, a, b;
      d = $urandom;
      ne = $urandom_range(2, 0);
      a = $urandom_range(38, 0);
      b = $urandom_range(37, 0);
      if (b >= a) b++;
      run_case(d, ne, a, b, ($urandom_range(7, 0) != 0), $urandom_range(1, 0) == 1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule